// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash bus and turns a single high-level request (program one byte, erase one sector, or erase the whole array) into the unlock and command write cycles the flash expects. It then polls the target location until the internal operation finishes. The result is one `done` or `err` pulse. Every bus write holds chip enable low around a write-enable pulse. Address and data are set up before the strobe falls and held until after it rises.

Completion is judged on two status bits of each polled read. Bit 7 equals the true data bit 7 once the flash has finished. Before that it reads inverted. Bit 6 flips on every read while the flash is busy. A read with a wrong bit 7 and a still bit 6 looks like a failure, but it may only be a read that raced the end of the operation. In that case the block reads the location twice more before it decides. A cycle-count timeout, set separately for program and for erase, ends polling that never converges.

Requests use a valid/ready handshake. A request is taken in a cycle where both `req_valid` and `req_ready` are high. After that, `req_ready` stays low until the result is reported, and `req_valid` is ignored for the whole time. The requester must hold its request fields stable only in the accepting cycle, because the block captures them then. Only one request is in flight at a time.

Top module: `flash_pe_ctrl`

## Requirements
- R1: `req_ready` is high in idle. A request is accepted when `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays low until the cycle in which `done` or `err` pulses. Requests offered while it is low cause no bus activity.
- R2: Bus write timing:
  - During a write, chip enable is low whenever write enable is low.
  - Address and data are driven, with the data driver enabled, at least one cycle before write enable falls.
  - They stay unchanged while write enable is low.
  - Data and chip enable still hold in the cycle in which write enable rises.
  - Output enable stays high during writes.
- R3: `req_op`=0 (program) writes, in order, AAh@5555h, 55h@2AAAh, A0h@5555h, then `req_data`@`req_addr`.
- R4: `req_op`=1 (sector erase) writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h@`req_addr`.
- R5: `req_op`=2 (chip erase) writes the same first five cycles as R4 and then 10h@5555h.
- R6: Status reads:
  - Each read drives chip and output enable low at `req_addr`.
  - During a read the data driver is off and write enable is high.
- R7: A status read whose bit 7 equals the expected bit ends the operation with a one-cycle `done`. The expected bit is `req_data[7]` for a program and 1 for either erase.
- R8: The block keeps polling in two cases:
  - a read with a wrong bit 7 whose bit 6 differs from the previous read's bit 6;
  - the first read of an operation when its bit 7 is wrong.
  Because of this, `done` never comes while the flash still reports busy.
- R9: If bit 7 is wrong and bit 6 equals the previous read's, exactly two more reads follow. `done` is reported if both show a correct bit 7, otherwise `err`, without waiting for the timeout.
- R10: `err` is reported at the end of a still-busy read once PROG_TIMEOUT (program) or ERASE_TIMEOUT (erase) cycles have passed since the last command write.
- R11: `done` and `err` are single-cycle pulses that never coincide. When either pulses, chip, write and output enables are high and the data driver is off.
- R12: A request with `req_op`=3 is answered with `err` two cycles after acceptance, with no bus cycle at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| req_addr | input | AW | Byte address to program, sector address, or poll location |
| req_data | input | 8 | Byte to program |
| done | output | 1 | Operation completed (pulse) |
| err | output | 1 | Operation failed or timed out (pulse) |
| f_addr | output | AW | Flash address bus |
| f_dq_out | output | 8 | Data driven to the flash |
| f_dq_oe | output | 1 | Data driver enable |
| f_dq_in | input | 8 | Data read from the flash |
| f_ce_n | output | 1 | Chip enable, active low |
| f_we_n | output | 1 | Write enable, active low |
| f_oe_n | output | 1 | Output enable, active low |

## Verification
The bench sweeps all three operations against a flash model in four behaviours, with several busy durations and several data bytes, including data whose bit 7 is set and clear. The first behaviour finishes cleanly. The second returns one stale status read right as the operation ends. The third fails permanently. The fourth never finishes. A design without the two-read recheck would report `err` in the stale-read case. A design that trusts a single still bit 6 would accept the permanent failure, and one that ignores the toggle would report `done` while the flash is still busy. Two more defects show up in the write log and strobe checks: unlock addresses swapped or the final command byte wrong, and write enable moving in the same cycle as address or data. A late request offered while busy, and the invalid op code, catch a handshake that takes a second request or starts bus traffic for a request it rejects.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  localparam logic [15:0] UNLOCK_A1 = 16'h5555;
  localparam logic [15:0] UNLOCK_A2 = 16'h2AAA;
  localparam logic [7:0]  KEY_1     = 8'hAA;
  localparam logic [7:0]  KEY_2     = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_pe_pkg::*;
#(
  parameter int AW = 16
) (
  input  op_e           op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          last
);
  localparam logic [AW-1:0] A1 = AW'(UNLOCK_A1);
  localparam logic [AW-1:0] A2 = AW'(UNLOCK_A2);

  always_comb begin
    wr_addr = A1;
    wr_data = KEY_1;
    unique case (step)
      3'd0: begin wr_addr = A1; wr_data = KEY_1; end
      3'd1: begin wr_addr = A2; wr_data = KEY_2; end
      3'd2: begin wr_addr = A1; wr_data = (op == OP_PROG) ? CMD_PROG : CMD_ERASE; end
      3'd3: begin
        if (op == OP_PROG) begin wr_addr = tgt_addr; wr_data = tgt_data; end
        else begin wr_addr = A1; wr_data = KEY_1; end
      end
      3'd4: begin wr_addr = A2; wr_data = KEY_2; end
      3'd5: begin
        if (op == OP_SECT) begin wr_addr = tgt_addr; wr_data = CMD_SECT; end
        else begin wr_addr = A1; wr_data = CMD_CHIP; end
      end
      default: begin wr_addr = A1; wr_data = KEY_1; end
    endcase
    last = (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);
  end
endmodule

// File: rtl/flash_bus_phy.sv
module flash_bus_phy #(
  parameter int AW        = 16,
  parameter int PULSE_CYC = 2,
  parameter int RD_CYC    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_wr,
  input  logic          go_rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  output logic          ack,
  output logic [7:0]    rd_byte,
  output logic [AW-1:0] f_addr,
  output logic [7:0]    f_dq_out,
  output logic          f_dq_oe,
  input  logic [7:0]    f_dq_in,
  output logic          f_ce_n,
  output logic          f_we_n,
  output logic          f_oe_n
);
  localparam int MAXC = (PULSE_CYC > RD_CYC) ? PULSE_CYC : RD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] RD_END    = CW'(RD_CYC - 1);

  typedef enum logic [2:0] {P_IDLE, P_SETUP, P_PULSE, P_HOLD, P_READ} pst_e;
  pst_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        P_IDLE: begin
          cnt_q <= '0;
          if (go_wr) begin
            addr_q <= addr;
            data_q <= data;
            st_q   <= P_SETUP;
          end else if (go_rd) begin
            addr_q <= addr;
            st_q   <= P_READ;
          end
        end
        P_SETUP: st_q <= P_PULSE;
        P_PULSE: begin
          if (cnt_q == PULSE_END) begin
            st_q  <= P_HOLD;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        P_HOLD: st_q <= P_IDLE;
        P_READ: begin
          if (cnt_q == RD_END) begin
            st_q  <= P_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign f_addr   = addr_q;
  assign f_dq_out = data_q;
  assign f_dq_oe  = (st_q == P_SETUP) || (st_q == P_PULSE) || (st_q == P_HOLD);
  assign f_ce_n   = (st_q == P_IDLE);
  assign f_we_n   = (st_q != P_PULSE);
  assign f_oe_n   = (st_q != P_READ);
  assign ack      = (st_q == P_HOLD) || ((st_q == P_READ) && (cnt_q == RD_END));
  assign rd_byte  = f_dq_in;

  assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !f_we_n |-> !f_ce_n);
  assert_setup_before_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_we_n) |-> ($stable(f_addr) && $stable(f_dq_out) && $past(f_dq_oe)));
  assert_hold_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_we_n) |-> ($stable(f_dq_out) && $stable(f_addr) && f_dq_oe && !f_ce_n));
  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !f_oe_n |-> (!f_dq_oe && f_we_n && !f_ce_n));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int AW            = 16,
  parameter int PULSE_CYC     = 2,
  parameter int RD_CYC        = 2,
  parameter int PROG_TIMEOUT  = 5000,
  parameter int ERASE_TIMEOUT = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] f_addr,
  output logic [7:0]    f_dq_out,
  output logic          f_dq_oe,
  input  logic [7:0]    f_dq_in,
  output logic          f_ce_n,
  output logic          f_we_n,
  output logic          f_oe_n
);
  localparam int TMAXI = (PROG_TIMEOUT > ERASE_TIMEOUT) ? PROG_TIMEOUT : ERASE_TIMEOUT;
  localparam int TW    = $clog2(TMAXI + 1);
  localparam logic [TW-1:0] TMAX = TW'(TMAXI);

  typedef enum logic [2:0] {S_IDLE, S_FAIL, S_WR, S_WR_W, S_RD, S_RD_W} st_e;
  st_e           st_q;
  op_e           op_q;
  logic [2:0]    step_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          exp7_q, prev6_q, have_prev_q;
  logic          rechk_q, rc_n_q, rc_bad_q;
  logic [TW-1:0] tmo_q;
  logic          done_q, err_q;

  logic [AW-1:0] cmd_addr, phy_addr;
  logic [7:0]    cmd_data, rd_byte;
  logic          cmd_last, ack, ok7;
  logic [TW-1:0] lim;

  flash_cmd_table #(.AW(AW)) u_tbl (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .wr_addr(cmd_addr), .wr_data(cmd_data), .last(cmd_last)
  );

  assign phy_addr = (st_q == S_RD) ? addr_q : cmd_addr;

  flash_bus_phy #(.AW(AW), .PULSE_CYC(PULSE_CYC), .RD_CYC(RD_CYC)) u_phy (
    .clk(clk), .rst_n(rst_n),
    .go_wr(st_q == S_WR), .go_rd(st_q == S_RD),
    .addr(phy_addr), .data(cmd_data),
    .ack(ack), .rd_byte(rd_byte),
    .f_addr(f_addr), .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in),
    .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
  );

  assign lim = (op_q == OP_PROG) ? TW'(PROG_TIMEOUT) : TW'(ERASE_TIMEOUT);
  assign ok7 = (rd_byte[7] == exp7_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; op_q <= OP_PROG; step_q <= '0;
      addr_q <= '0; data_q <= '0; exp7_q <= 1'b0;
      prev6_q <= 1'b0; have_prev_q <= 1'b0;
      rechk_q <= 1'b0; rc_n_q <= 1'b0; rc_bad_q <= 1'b0;
      tmo_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if ((st_q == S_RD || st_q == S_RD_W) && tmo_q != TMAX) tmo_q <= tmo_q + 1'b1;
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          op_q <= op_e'(req_op); addr_q <= req_addr; data_q <= req_data;
          exp7_q <= (op_e'(req_op) == OP_PROG) ? req_data[7] : 1'b1;
          step_q <= '0; have_prev_q <= 1'b0; rechk_q <= 1'b0;
          st_q <= (op_e'(req_op) == OP_BAD) ? S_FAIL : S_WR;
        end
        S_FAIL: begin err_q <= 1'b1; st_q <= S_IDLE; end
        S_WR:   st_q <= S_WR_W;
        S_WR_W: if (ack) begin
          step_q <= step_q + 1'b1;
          if (cmd_last) begin tmo_q <= '0; st_q <= S_RD; end
          else st_q <= S_WR;
        end
        S_RD:   st_q <= S_RD_W;
        S_RD_W: if (ack) begin
          if (rechk_q) begin
            if (rc_n_q) begin
              st_q <= S_IDLE;
              if (rc_bad_q || !ok7) err_q <= 1'b1; else done_q <= 1'b1;
            end else begin
              rc_n_q <= 1'b1; rc_bad_q <= !ok7; st_q <= S_RD;
            end
          end else if (ok7) begin
            done_q <= 1'b1; st_q <= S_IDLE;
          end else if (have_prev_q && rd_byte[6] == prev6_q) begin
            rechk_q <= 1'b1; rc_n_q <= 1'b0; rc_bad_q <= 1'b0; st_q <= S_RD;
          end else if (tmo_q >= lim) begin
            err_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            prev6_q <= rd_byte[6]; have_prev_q <= 1'b1; st_q <= S_RD;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);
  assert_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> (!done && !err));
  assert_bus_quiet_on_report_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (req_ready && f_ce_n && f_we_n && f_oe_n && !f_dq_oe));
  assert_bad_op_no_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd3) |=> (f_ce_n ##1 (err && f_ce_n)));
endmodule

// File: tb/flash_pe_ctrl_tb_top.sv
module flash_pe_ctrl_tb_top;
  localparam int AW = 16;
  localparam int PTO = 120;
  localparam int ETO = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic done, err;
  logic [AW-1:0] f_addr;
  logic [7:0] f_dq_out, f_dq_in;
  logic f_dq_oe, f_ce_n, f_we_n, f_oe_n;

  always #2 clk = ~clk;

  flash_pe_ctrl #(.AW(AW), .PULSE_CYC(2), .RD_CYC(2),
                  .PROG_TIMEOUT(PTO), .ERASE_TIMEOUT(ETO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .f_addr(f_addr), .f_dq_out(f_dq_out),
    .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in), .f_ce_n(f_ce_n),
    .f_we_n(f_we_n), .f_oe_n(f_oe_n)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model state
  int m_mode = 0, busy_set = 0, busy_cnt = 0, glitch_left = 0;
  int nw = 0, exp_n = 4, nrd = 0, vw = 0, vr = 0, last_wr_cyc = 0;
  logic [7:0] fval = 8'hFF;
  logic exp7 = 1'b1, tog = 1'b0;
  logic [AW-1:0] cur_addr = '0, fa = '0, paddr = '0;
  logic [7:0] fd = '0, pdq = '0;
  logic pwe = 1'b1, poe = 1'b1, pce = 1'b1;
  logic [AW-1:0] wa [0:7];
  logic [7:0] wd [0:7];

  assign f_dq_in = (m_mode == 3 || m_mode == 2 || busy_cnt > 0 || glitch_left > 0)
                   ? {~exp7, tog, 6'b0} : fval;

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (pwe && !f_we_n) begin
      if (pce || f_addr != paddr || f_dq_out != pdq) vw = vw + 1;
      fa = f_addr; fd = f_dq_out;
    end
    if (!f_we_n && (f_ce_n || f_addr != fa || f_dq_out != fd || !f_dq_oe || !f_oe_n)) vw = vw + 1;
    if (!pwe && f_we_n) begin
      if (f_dq_out != fd || f_ce_n || !f_dq_oe) vw = vw + 1;
      if (nw < 8) begin wa[nw] = fa; wd[nw] = fd; end
      nw = nw + 1;
      if (nw == exp_n) begin busy_cnt = busy_set; last_wr_cyc = cyc; end
    end
    if (!f_oe_n && (f_ce_n || f_dq_oe || !f_we_n || f_addr != cur_addr)) vr = vr + 1;
    if (poe && !f_oe_n && (busy_cnt > 0 || m_mode == 3)) tog = ~tog;
    if (!poe && f_oe_n) begin
      nrd = nrd + 1;
      if (busy_cnt == 0 && glitch_left > 0) glitch_left = glitch_left - 1;
    end
    pwe = f_we_n; poe = f_oe_n; pce = f_ce_n; paddr = f_addr; pdq = f_dq_out;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic exp_wr(input int op, input int i, input logic [15:0] a, input logic [7:0] d,
                        output logic [15:0] ea, output logic [7:0] ed);
    case (i)
      0: begin ea = 16'h5555; ed = 8'hAA; end
      1: begin ea = 16'h2AAA; ed = 8'h55; end
      2: begin ea = 16'h5555; ed = (op == 0) ? 8'hA0 : 8'h80; end
      3: begin ea = (op == 0) ? a : 16'h5555; ed = (op == 0) ? d : 8'hAA; end
      4: begin ea = 16'h2AAA; ed = 8'h55; end
      default: begin ea = (op == 1) ? a : 16'h5555; ed = (op == 1) ? 8'h30 : 8'h10; end
    endcase
  endtask

  task automatic run_op(input int op, input logic [15:0] a, input logic [7:0] d,
                        input int mode, input int bsy);
    bit dn, er;
    int t_end, rdy_hi, bad_i, lim;
    logic [15:0] ea;
    logic [7:0] ed;
    string seq_tag;
    dn = 0; er = 0; t_end = 0; rdy_hi = 0; bad_i = -1;
    lim = (op == 0) ? PTO : ETO;
    seq_tag = (op == 0) ? "R3 program sequence" : (op == 1) ? "R4 sector erase sequence"
                                                            : "R5 chip erase sequence";
    cur_addr = a; m_mode = mode; busy_set = bsy; glitch_left = (mode == 1) ? 1 : 0;
    nw = 0; nrd = 0; vw = 0; vr = 0; exp_n = (op == 0) ? 4 : 6;
    fval = (op == 0) ? d : 8'hFF; exp7 = fval[7];
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3000 && !dn && !er; k++) begin
      if (k == 2) begin req_valid = 1'b1; req_op = (op == 0) ? 2'd1 : 2'd0; req_addr = ~a; end
      if (k == 4) req_valid = 1'b0;
      @(negedge clk);
      if (done || err) begin dn = done; er = err; t_end = cyc; end
      else if (req_ready) rdy_hi++;
    end
    chk(rdy_hi == 0, "R1 ready low while busy", rdy_hi, 0);
    for (int i = 0; i < exp_n; i++) begin
      exp_wr(op, i, a, d, ea, ed);
      if (bad_i < 0 && (wa[i] != ea || wd[i] != ed)) bad_i = i;
    end
    chk(nw == exp_n, "R1 write count (no second request)", nw, exp_n);
    chk(bad_i < 0, seq_tag, bad_i, -1);
    chk(vw == 0, "R2 write strobe timing", vw, 0);
    chk(vr == 0, "R6 read cycle shape", vr, 0);
    if (mode <= 1) begin
      chk(dn && !er, (mode == 1) ? "R9 stale read accepted after recheck" : "R7 completion done",
          {dn, er}, 2'b10);
      chk(t_end - last_wr_cyc >= bsy, "R8 no done while busy", t_end - last_wr_cyc, bsy);
    end else if (mode == 2) begin
      chk(er && !dn, "R9 persistent failure rejected", {dn, er}, 2'b01);
      chk(t_end - last_wr_cyc < lim, "R9 rejection before timeout", t_end - last_wr_cyc, lim);
    end else begin
      chk(er && !dn, "R10 timeout error", {dn, er}, 2'b01);
      chk(t_end - last_wr_cyc >= lim && t_end - last_wr_cyc <= lim + 12,
          "R10 timeout window", t_end - last_wr_cyc, lim);
    end
    chk(req_ready && f_ce_n && f_we_n && f_oe_n && !f_dq_oe, "R11 bus idle at report",
        {req_ready, f_ce_n, f_we_n, f_oe_n, f_dq_oe}, 5'b11110);
    @(negedge clk);
    chk(!done && !err, "R11 single-cycle pulse", {done, err}, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !err && f_ce_n && f_we_n && f_oe_n && !f_dq_oe,
        "R1 reset state", {req_ready, done, err, f_ce_n, f_we_n, f_oe_n, f_dq_oe}, 7'b1001110);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 3; op++)
      for (int mode = 0; mode < 4; mode++)
        for (int bi = 0; bi < 3; bi++)
          for (int di = 0; di < 3; di++) begin
            logic [7:0] d;
            logic [15:0] a;
            d = (di == 0) ? 8'h00 : (di == 1) ? 8'h80 : 8'h5A;
            a = 16'h1000 * 16'(di + 1) + 16'(op * 7 + mode);
            run_op(op, a, d, mode, (bi == 0) ? 0 : (bi == 1) ? 5 : 23);
          end
    begin
      int rdy_hi;
      bit er;
      rdy_hi = 0; er = 0;
      nw = 0; nrd = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd3; req_addr = 16'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready && !err, "R12 bad op wait cycle", {req_ready, err}, 0);
      @(negedge clk);
      chk(err && !done, "R12 bad op error", {done, err}, 2'b01);
      repeat (4) @(negedge clk);
      chk(nw == 0 && nrd == 0, "R12 no bus cycles", nw + nrd, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule